// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Sequencer

This block is the card-side control for a plug-and-play expansion card that host software configures through two shared ports. One port sets an index, and the other carries data writes and reads for that index. The sequencer tracks which of four configuration states the card is in: waiting for the initiation key, asleep, isolating, or being configured. It decodes the card-level indices and holds the card select number (CSN), the logical device number and the programmed read-port address. It serves a fixed block of resource bytes one at a time, and it issues one-shot reset and exit actions when software asks for them.

An external key matcher pulses `keyDetected` once the initiation key has been seen. After that, software wakes the card by CSN, assigns a CSN during isolation, reads the resource stream in configuration, and sends the card back to waiting with a control write. An index write and a data access may share a cycle. In that case the data access uses the new index.

Top module: `pnp_card_seq`

## Requirements
- R1: After reset the card is waiting for the key (cardState 0), with CSN 0, logical device 0, resource position 0, readPort 0, ldevReset low and rdData 0.
- R2: While waiting for the key, a keyDetected pulse moves the card to Sleep (cardState 1). Every index and data write is ignored in this state, and every read returns 0x00.
- R3: A data write to index 0x00 while awake sets readPort to the written byte shifted left by two, with the low two bits zero.
- R4: A wake write (index 0x03) in Sleep whose byte equals the CSN moves the card to Isolation (cardState 2) if the byte is zero, and to Config (cardState 3) otherwise.
- R5: A wake write whose byte differs from the CSN leaves a sleeping card in Sleep, and sends a card in Isolation or Config to Sleep.
- R6: A wake write whose byte equals the CSN restarts the resource stream at its first byte.
- R7: A control write (index 0x02) with bit 2 set clears the CSN to zero.
- R8: A control write with bit 1 set returns the card to waiting for the key, and the CSN is kept.
- R9: A control write with bit 0 set raises ldevReset for exactly one cycle, starting the cycle after the write. The CSN and state are unchanged. Bits 0, 1 and 2 are not stored.
- R10: A write to index 0x06 in Isolation or Config sets the CSN, and a read of index 0x06 in Config returns it.
- R11: A write to index 0x07 in Config selects a logical device when the byte is below NUM_LDEV and is otherwise ignored. A read of index 0x07 returns the selection, which is always 0x00 when NUM_LDEV is 1.
- R12: In Config, a read of index 0x05 returns bit 0 set when a resource byte is ready. A read of index 0x04 with bit 0 set returns the next byte of RES_IMAGE (byte 0 in bits 7:0) and advances the stream.
- R13: The ready bit is clear for the one cycle after each accepted resource read, and stays clear once all RES_DEPTH bytes are read. A resource read while not ready returns 0x00 and does not advance the stream.
- R14: Every read updates rdData at the next clock edge. Reads outside Config, and reads of any other index, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyDetected | input | 1 | One-cycle pulse from the key matcher |
| idxWrEn | input | 1 | Index port write strobe |
| idxIn | input | 8 | Index value |
| dataWrEn | input | 1 | Data port write strobe |
| dataRdEn | input | 1 | Data port read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid the cycle after dataRdEn |
| cardState | output | 2 | 0 wait key, 1 sleep, 2 isolation, 3 config |
| ldevReset | output | 1 | One-cycle logical device reset pulse |
| readPort | output | 10 | Programmed read-port address |

## Verification
The status bit is clear for only a single cycle after each resource read. To see that cycle from the ports, the bench issues a status read in the very next cycle, using an index write and a data read in the same cycle. It also issues a back-to-back resource read, which must be refused. Checking that a matching wake rewinds the stream takes several steps: the bench first reads part of the stream, then wakes the card with its own CSN while it is already in Config, and expects the first byte again. Checking that the CSN survives a return to waiting also takes several steps: the bench assigns a nonzero CSN in isolation, leaves, re-keys, and wakes with that CSN directly into Config.

// File: rtl/pnp_seq_pkg.sv
package pnp_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } cardState_e;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_RES    = 8'h04;
  localparam logic [7:0] IDX_STAT   = 8'h05;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;

  // Strobes from control to datapath, all valid in the cycle of the access
  typedef struct packed {
    logic setPort;
    logic clrCsn;
    logic ldevRst;
    logic ptrClr;
    logic wrCsn;
    logic wrLdn;
    logic rdLoad;
    logic rdRes;
    logic rdStat;
    logic rdCsn;
    logic rdLdn;
  } dpStrobe_t;

endpackage

// File: rtl/pnp_seq_ctrl.sv
module pnp_seq_ctrl
  import pnp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyDetected,
  input  logic       idxWrEn,
  input  logic [7:0] idxIn,
  input  logic       dataWrEn,
  input  logic       dataRdEn,
  input  logic [7:0] wrData,
  input  logic [7:0] csnQ,
  output cardState_e stateQ,
  output dpStrobe_t  strb
);

  logic [7:0] idxQ;
  logic [7:0] effIdx;
  logic       awake;
  logic       inCfg;
  logic       wrOk;
  logic       rdOk;
  logic       ctrlWr;
  logic       wakeWr;
  logic       csnMatch;
  logic       goWait;
  cardState_e stateD;

  assign awake    = (stateQ != ST_WAIT_KEY);
  assign inCfg    = (stateQ == ST_CONFIG);
  assign effIdx   = idxWrEn ? idxIn : idxQ;
  assign wrOk     = dataWrEn && awake;
  assign rdOk     = dataRdEn && inCfg;
  assign ctrlWr   = wrOk && (effIdx == IDX_CTRL);
  assign wakeWr   = wrOk && (effIdx == IDX_WAKE);
  assign csnMatch = (wrData == csnQ);
  assign goWait   = ctrlWr && wrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                idxQ <= 8'h00;
    else if (idxWrEn && awake) idxQ <= idxIn;
  end

  always_comb begin
    strb         = '0;
    strb.setPort = wrOk && (effIdx == IDX_RDPORT);
    strb.clrCsn  = ctrlWr && wrData[2];
    strb.ldevRst = ctrlWr && wrData[0];
    strb.ptrClr  = wakeWr && csnMatch;
    strb.wrCsn   = wrOk && (effIdx == IDX_CSN) &&
                   (stateQ == ST_ISOLATE || stateQ == ST_CONFIG);
    strb.wrLdn   = wrOk && inCfg && (effIdx == IDX_LDN);
    strb.rdLoad  = dataRdEn;
    strb.rdRes   = rdOk && (effIdx == IDX_RES);
    strb.rdStat  = rdOk && (effIdx == IDX_STAT);
    strb.rdCsn   = rdOk && (effIdx == IDX_CSN);
    strb.rdLdn   = rdOk && (effIdx == IDX_LDN);
  end

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_WAIT_KEY) begin
      if (keyDetected) stateD = ST_SLEEP;
    end else if (goWait) begin
      stateD = ST_WAIT_KEY;
    end else if (wakeWr) begin
      if (stateQ == ST_SLEEP) begin
        if (csnMatch) stateD = (wrData == 8'h00) ? ST_ISOLATE : ST_CONFIG;
      end else if (!csnMatch) begin
        stateD = ST_SLEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_WAIT_KEY;
    else       stateQ <= stateD;
  end

  // R2: without a key pulse a waiting card stays waiting
  a_r2_waitkey_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_KEY && !keyDetected) |=> stateQ == ST_WAIT_KEY);

  // R4: a matching zero wake from sleep lands in isolation
  a_r4_wake_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && strb.ptrClr && wrData == 8'h00) |=> stateQ == ST_ISOLATE);

  // R8: an exit request from any awake state reaches waiting
  a_r8_exit: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && stateQ != ST_WAIT_KEY && effIdx == IDX_CTRL && wrData[1])
      |=> stateQ == ST_WAIT_KEY);

endmodule

// File: rtl/pnp_seq_dp.sv
module pnp_seq_dp
  import pnp_seq_pkg::*;
#(
  parameter int NUM_LDEV  = 2,
  parameter int RES_DEPTH = 4,
  parameter logic [RES_DEPTH*8-1:0] RES_IMAGE = 32'h472B_150A
)(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic [7:0] wrData,
  output logic [7:0] csnQ,
  output logic [7:0] rdData,
  output logic       ldevReset,
  output logic [9:0] readPort
);

  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam int PTR_W = $clog2(RES_DEPTH + 1);
  localparam int SEL_W = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(RES_DEPTH);

  logic [7:0]       portQ;
  logic [PTR_W-1:0] ptrQ;
  logic             justRdQ;
  logic             resReady;
  logic             resAccept;
  logic [SEL_W-1:0] resSel;
  logic [7:0]       resByte;
  logic [LDN_W-1:0] ldnQ;
  logic [7:0]       resRom [RES_DEPTH];

  for (genvar g = 0; g < RES_DEPTH; g++) begin : g_rom
    assign resRom[g] = RES_IMAGE[g*8 +: 8];
  end

  assign resReady  = (ptrQ < PTR_END) && !justRdQ;
  assign resAccept = strb.rdRes && resReady;
  assign resSel    = SEL_W'(ptrQ);
  assign resByte   = resRom[resSel];
  assign readPort  = {portQ, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csnQ      <= 8'h00;
      portQ     <= 8'h00;
      ptrQ      <= '0;
      justRdQ   <= 1'b0;
      ldevReset <= 1'b0;
    end else begin
      if (strb.clrCsn)      csnQ <= 8'h00;
      else if (strb.wrCsn)  csnQ <= wrData;
      if (strb.setPort)     portQ <= wrData;
      if (strb.ptrClr)      ptrQ <= '0;
      else if (resAccept)   ptrQ <= ptrQ + 1'b1;
      justRdQ   <= resAccept;
      ldevReset <= strb.ldevRst;
    end
  end

  if (NUM_LDEV > 1) begin : g_multi_ldn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ldnQ <= '0;
      else if (strb.wrLdn && (wrData < 8'(NUM_LDEV))) ldnQ <= LDN_W'(wrData);
    end
  end else begin : g_single_ldn
    assign ldnQ = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 8'h00;
    else if (strb.rdLoad) begin
      if (strb.rdRes)       rdData <= resAccept ? resByte : 8'h00;
      else if (strb.rdStat) rdData <= {7'b0, resReady};
      else if (strb.rdCsn)  rdData <= csnQ;
      else if (strb.rdLdn)  rdData <= 8'(ldnQ);
      else                  rdData <= 8'h00;
    end
  end

  // R7: the CSN clear strobe empties the CSN
  a_r7_csn_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCsn |=> csnQ == 8'h00);

  // R9: the reset pulse only follows a requesting write
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    ldevReset |-> $past(strb.ldevRst));

  // R6: a matching wake rewinds the stream
  a_r6_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrClr |=> ptrQ == '0);

  // R13: ready drops right after an accepted read
  a_r13_status_drop: assert property (@(posedge clk) disable iff (!rstN)
    resAccept |=> !resReady);

  // R13: position never passes the end of the image
  a_r13_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= PTR_END);

endmodule

// File: rtl/pnp_card_seq.sv
module pnp_card_seq
  import pnp_seq_pkg::*;
#(
  parameter int NUM_LDEV  = 2,
  parameter int RES_DEPTH = 4,
  parameter logic [RES_DEPTH*8-1:0] RES_IMAGE = 32'h472B_150A
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyDetected,
  input  logic       idxWrEn,
  input  logic [7:0] idxIn,
  input  logic       dataWrEn,
  input  logic       dataRdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [1:0] cardState,
  output logic       ldevReset,
  output logic [9:0] readPort
);

  cardState_e stateQ;
  dpStrobe_t  strb;
  logic [7:0] csnQ;

  pnp_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyDetected(keyDetected),
    .idxWrEn(idxWrEn), .idxIn(idxIn), .dataWrEn(dataWrEn),
    .dataRdEn(dataRdEn), .wrData(wrData), .csnQ(csnQ),
    .stateQ(stateQ), .strb(strb)
  );

  pnp_seq_dp #(
    .NUM_LDEV(NUM_LDEV), .RES_DEPTH(RES_DEPTH), .RES_IMAGE(RES_IMAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .csnQ(csnQ), .rdData(rdData), .ldevReset(ldevReset),
    .readPort(readPort)
  );

  assign cardState = stateQ;

endmodule

// File: tb/pnp_card_seq_test.sv
`timescale 1ns/1ps
module pnp_card_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       keyDetected = 1'b0;
  logic       idxWrEn = 1'b0;
  logic [7:0] idxIn = 8'h00;
  logic       dataWrEn = 1'b0;
  logic       dataRdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, rdData1;
  logic [1:0] cardState, cardState1;
  logic       ldevReset, ldevReset1;
  logic [9:0] readPort, readPort1;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  pnp_card_seq uut (
    .clk(clk), .rstN(rstN), .keyDetected(keyDetected), .idxWrEn(idxWrEn),
    .idxIn(idxIn), .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .wrData(wrData),
    .rdData(rdData), .cardState(cardState), .ldevReset(ldevReset),
    .readPort(readPort)
  );

  // Single-device variant sharing the same stimulus (R11)
  pnp_card_seq #(.NUM_LDEV(1)) uut1 (
    .clk(clk), .rstN(rstN), .keyDetected(keyDetected), .idxWrEn(idxWrEn),
    .idxIn(idxIn), .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .wrData(wrData),
    .rdData(rdData1), .cardState(cardState1), .ldevReset(ldevReset1),
    .readPort(readPort1)
  );

  typedef struct packed {
    logic [1:0] op;    // 0 idle, 1 key, 2 write, 3 read
    logic [7:0] idx;
    logic [7:0] data;
    logic [1:0] st;
    logic       chk;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 8'h06, 8'h00, 2'd0, 1'b1, 8'h00, 4'd14}, // R14 read while waiting
    '{2'd2, 8'h03, 8'h00, 2'd0, 1'b0, 8'h00, 4'd2 }, // R2 wake ignored
    '{2'd2, 8'h06, 8'h05, 2'd0, 1'b0, 8'h00, 4'd2 }, // R2 csn write ignored
    '{2'd1, 8'h00, 8'h00, 2'd1, 1'b0, 8'h00, 4'd2 }, // R2 key to sleep
    '{2'd2, 8'h03, 8'h05, 2'd1, 1'b0, 8'h00, 4'd5 }, // R5 mismatch stays asleep
    '{2'd2, 8'h03, 8'h00, 2'd2, 1'b0, 8'h00, 4'd4 }, // R4 zero wake
    '{2'd3, 8'h06, 8'h00, 2'd2, 1'b1, 8'h00, 4'd14}, // R14 read in isolation
    '{2'd2, 8'h06, 8'h03, 2'd2, 1'b0, 8'h00, 4'd10}, // R10 assign csn
    '{2'd2, 8'h03, 8'h07, 2'd1, 1'b0, 8'h00, 4'd5 }, // R5 mismatch to sleep
    '{2'd2, 8'h03, 8'h03, 2'd3, 1'b0, 8'h00, 4'd4 }, // R4 nonzero wake
    '{2'd3, 8'h06, 8'h00, 2'd3, 1'b1, 8'h03, 4'd10}, // R10 readback
    '{2'd3, 8'h05, 8'h00, 2'd3, 1'b1, 8'h01, 4'd12}, // R12 ready
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h0A, 4'd12}, // R12 byte 0
    '{2'd3, 8'h05, 8'h00, 2'd3, 1'b1, 8'h00, 4'd13}, // R13 drop
    '{2'd3, 8'h05, 8'h00, 2'd3, 1'b1, 8'h01, 4'd13}, // R13 back
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h15, 4'd12}, // R12 byte 1
    '{2'd2, 8'h03, 8'h03, 2'd3, 1'b0, 8'h00, 4'd6 }, // R6 matched wake
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h0A, 4'd6 }, // R6 restart
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h00, 4'd13}, // R13 refused
    '{2'd2, 8'h07, 8'h01, 2'd3, 1'b0, 8'h00, 4'd11}, // R11 select 1
    '{2'd3, 8'h07, 8'h00, 2'd3, 1'b1, 8'h01, 4'd11}, // R11 readback
    '{2'd2, 8'h07, 8'h05, 2'd3, 1'b0, 8'h00, 4'd11}, // R11 out of range
    '{2'd3, 8'h07, 8'h00, 2'd3, 1'b1, 8'h01, 4'd11}, // R11 unchanged
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h15, 4'd12}, // R12
    '{2'd0, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00, 4'd12},
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h2B, 4'd12}, // R12
    '{2'd0, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00, 4'd12},
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h47, 4'd12}, // R12 last byte
    '{2'd0, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00, 4'd13},
    '{2'd3, 8'h05, 8'h00, 2'd3, 1'b1, 8'h00, 4'd13}, // R13 exhausted
    '{2'd3, 8'h04, 8'h00, 2'd3, 1'b1, 8'h00, 4'd13}, // R13 no byte
    '{2'd2, 8'h02, 8'h04, 2'd3, 1'b0, 8'h00, 4'd7 }, // R7 clear csn
    '{2'd3, 8'h06, 8'h00, 2'd3, 1'b1, 8'h00, 4'd7 }, // R7 csn reads 0
    '{2'd2, 8'h02, 8'h02, 2'd0, 1'b0, 8'h00, 4'd8 }, // R8 exit
    '{2'd3, 8'h06, 8'h00, 2'd0, 1'b1, 8'h00, 4'd14}  // R14
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies one op across the next rising edge
  task automatic step(input logic [1:0] op, input logic [7:0] idx,
                      input logic [7:0] data);
    keyDetected = (op == 2'd1);
    idxWrEn     = (op >= 2'd2);
    idxIn       = idx;
    dataWrEn    = (op == 2'd2);
    dataRdEn    = (op == 2'd3);
    wrData      = data;
    @(negedge clk);
    keyDetected = 1'b0;
    idxWrEn     = 1'b0;
    dataWrEn    = 1'b0;
    dataRdEn    = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", cardState, 0);
    check("R1 readPort", readPort, 0);
    check("R1 ldevReset", ldevReset, 0);
    check("R1 rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].idx, VEC[i].data);
      check($sformatf("R%0d vec %0d state", VEC[i].req, i), cardState, VEC[i].st);
      if (VEC[i].chk)
        check($sformatf("R%0d vec %0d rdData", VEC[i].req, i), rdData, VEC[i].rd);
      if (VEC[i].op == 2'd3 && VEC[i].idx == 8'h07)
        check("R11 single device ldn", rdData1, 0);
    end

    // R8: CSN survives a return to waiting
    step(2'd1, 8'h00, 8'h00);
    step(2'd2, 8'h03, 8'h00);
    step(2'd2, 8'h06, 8'h09);
    step(2'd2, 8'h02, 8'h02);
    check("R8 back to wait", cardState, 0);
    step(2'd1, 8'h00, 8'h00);
    step(2'd2, 8'h03, 8'h09);
    check("R8 wake by kept csn", cardState, 3);
    step(2'd3, 8'h06, 8'h00);
    check("R8 csn kept", rdData, 8'h09);

    // R9: one-cycle logical device reset
    step(2'd2, 8'h02, 8'h01);
    check("R9 pulse high", ldevReset, 1);
    check("R9 state kept", cardState, 3);
    step(2'd0, 8'h00, 8'h00);
    check("R9 pulse gone", ldevReset, 0);
    step(2'd3, 8'h06, 8'h00);
    check("R9 csn kept", rdData, 8'h09);

    // R3: read-port address
    step(2'd2, 8'h00, 8'hA5);
    check("R3 readPort", readPort, 10'h294);

    // R1: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 state after reset", cardState, 0);
    check("R1 readPort after reset", readPort, 0);
    check("R1 rdData after reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    step(2'd1, 8'h00, 8'h00);
    step(2'd2, 8'h03, 8'h00);
    check("R1 csn is zero", cardState, 2);
    step(2'd2, 8'h06, 8'h04);
    step(2'd2, 8'h02, 8'h02);
    step(2'd1, 8'h00, 8'h00);
    step(2'd2, 8'h03, 8'h04);
    step(2'd3, 8'h07, 8'h00);
    check("R1 ldn is zero", rdData, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule